// File: doc/BRIEF.md
# APB Three-Window Address Decoder

This block links one APB requester to three APB completers. It compares the upper part of the 32-bit transfer address against three consecutive 256-byte windows and raises one select line, for the completer that owns the address. The transfer enable, write direction and write data go unchanged to all three completers. The completers also receive the low address byte, which is the offset inside their own window.

Each completer drives its own private read-data bus and its own ready line. The decoder does not use a shared tri-state bus. It picks the addressed completer's read data and ready with a one-hot AND-OR multiplexer.

An address outside all three windows selects no completer. For such an address the decoder returns all-zero read data with ready high, so a stray access completes in the minimum two-phase APB transfer and cannot stall the bus. The whole block is combinational. Flow control stays with APB: the requester holds a transfer in its access phase until `m_pready` is high, and `m_pready` is the addressed completer's ready line.

Top module: `apb_tri_decoder`

## Requirements
- R1: An address whose bits [31:8] equal 0x400500 (0x40050000 to 0x400500FF) raises `s_psel[0]` while `m_psel` is high.
- R2: An address whose bits [31:8] equal 0x400501 (0x40050100 to 0x400501FF) raises `s_psel[1]` while `m_psel` is high.
- R3: An address whose bits [31:8] equal 0x400502 (0x40050200 to 0x400502FF) raises `s_psel[2]` while `m_psel` is high.
- R4: At most one bit of `s_psel` is high at any time. All bits of `s_psel` are low whenever `m_psel` is low.
- R5: `s_penable`, `s_pwrite` and `s_pwdata` equal `m_penable`, `m_pwrite` and `m_pwdata` at all times, whatever the address.
- R6: `s_paddr` equals `m_paddr[7:0]`, the byte offset inside the window.
- R7: For a mapped address, `m_prdata` equals that completer's slice of `s_prdata`, and `m_pready` equals its bit of `s_pready`. Completer k owns bits [32k+31:32k] of `s_prdata` and bit k of `s_pready`. The data and ready of the other completers have no effect.
- R8: For an address whose bits [31:8] are outside 0x400500 to 0x400502, no select is raised, `m_prdata` is zero and `m_pready` is high.
- R9: The window edges are exact. 0x400500FF and 0x400501FF belong to the lower window, and 0x40050100 and 0x40050200 belong to the upper window. 0x4005FFFF, 0x40050300 and 0x4004FFFF are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_psel | input | 1 | Requester select for this decoder |
| m_penable | input | 1 | Requester access-phase enable |
| m_pwrite | input | 1 | Requester write direction (1 = write) |
| m_paddr | input | 32 | Requester byte address |
| m_pwdata | input | 32 | Requester write data |
| m_prdata | output | 32 | Read data returned to the requester |
| m_pready | output | 1 | Ready returned to the requester |
| s_psel | output | 3 | One select per completer, bit k for window k |
| s_penable | output | 1 | Enable broadcast to all completers |
| s_pwrite | output | 1 | Write direction broadcast to all completers |
| s_paddr | output | 8 | Offset inside the window, broadcast |
| s_pwdata | output | 32 | Write data broadcast |
| s_prdata | input | 96 | Private read-data buses, completer k at [32k+31:32k] |
| s_pready | input | 3 | Ready from each completer, bit k for completer k |

## Verification
The decoder is driven with one address from inside each window, with both the read and the write direction. This separates a select that follows the address from one that follows the direction or a fixed slot. Every address is repeated with `m_psel` low, to show that the requester's select gates every output select. Addresses are placed on both sides of each window edge and just past the last window, to catch an off-by-one in the page compare. Each completer gets distinct read data, and the ready pattern changes between steps, so that returned data or ready taken from the wrong completer is detected.

// File: rtl/apb_tri_dec_pkg.sv
package apb_tri_dec_pkg;
  parameter int unsigned SLOT_N   = 3;
  parameter int unsigned ADDR_W   = 32;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned OFS_W    = 8;
  parameter int unsigned PAGE_W   = ADDR_W - OFS_W;
  parameter logic [PAGE_W-1:0] FIRST_PAGE = 24'h400500;
endpackage

// File: rtl/apb_win_match.sv
module apb_win_match
  import apb_tri_dec_pkg::*;
#(
  parameter int unsigned N_SLOT = SLOT_N,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned OW     = OFS_W,
  parameter logic [AW-OW-1:0] BASE_PAGE = FIRST_PAGE
) (
  input  logic [AW-1:0]     addr,
  output logic [N_SLOT-1:0] hit
);
  localparam int unsigned PW = AW - OW;

  logic [PW-1:0] page;
  assign page = addr[AW-1:OW];

  // one comparator per window; windows are consecutive pages
  for (genvar k = 0; k < N_SLOT; k++) begin : g_win
    localparam logic [PW-1:0] PAGE_K = BASE_PAGE + PW'(k);
    assign hit[k] = (page == PAGE_K);
  end
endmodule

// File: rtl/apb_rsp_mux.sv
module apb_rsp_mux
  import apb_tri_dec_pkg::*;
#(
  parameter int unsigned N_SLOT = SLOT_N,
  parameter int unsigned DW     = DATA_W
) (
  input  logic [N_SLOT-1:0]    hit,
  input  logic [N_SLOT*DW-1:0] rdata_all,
  input  logic [N_SLOT-1:0]    ready_all,
  output logic [DW-1:0]        rdata,
  output logic                 ready
);
  // AND-OR mux: hit is one-hot or zero, so OR-ing masked slices is exact
  always_comb begin
    rdata = '0;
    ready = ~|hit;
    for (int k = 0; k < N_SLOT; k++) begin
      if (hit[k]) begin
        rdata = rdata | rdata_all[k*DW +: DW];
        ready = ready | ready_all[k];
      end
    end
  end
endmodule

// File: rtl/apb_tri_decoder.sv
module apb_tri_decoder
  import apb_tri_dec_pkg::*;
#(
  parameter int unsigned N_SLOT = SLOT_N,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned OW     = OFS_W,
  parameter logic [AW-OW-1:0] BASE_PAGE = FIRST_PAGE
) (
  input  logic                 m_psel,
  input  logic                 m_penable,
  input  logic                 m_pwrite,
  input  logic [AW-1:0]        m_paddr,
  input  logic [DW-1:0]        m_pwdata,
  output logic [DW-1:0]        m_prdata,
  output logic                 m_pready,
  output logic [N_SLOT-1:0]    s_psel,
  output logic                 s_penable,
  output logic                 s_pwrite,
  output logic [OW-1:0]        s_paddr,
  output logic [DW-1:0]        s_pwdata,
  input  logic [N_SLOT*DW-1:0] s_prdata,
  input  logic [N_SLOT-1:0]    s_pready
);
  logic [N_SLOT-1:0] win_hit;

  apb_win_match #(
    .N_SLOT(N_SLOT), .AW(AW), .OW(OW), .BASE_PAGE(BASE_PAGE)
  ) u_match (
    .addr (m_paddr),
    .hit  (win_hit)
  );

  // the requester's select gates every completer select
  assign s_psel    = win_hit & {N_SLOT{m_psel}};
  assign s_penable = m_penable;
  assign s_pwrite  = m_pwrite;
  assign s_paddr   = m_paddr[OW-1:0];
  assign s_pwdata  = m_pwdata;

  apb_rsp_mux #(
    .N_SLOT(N_SLOT), .DW(DW)
  ) u_mux (
    .hit       (win_hit),
    .rdata_all (s_prdata),
    .ready_all (s_pready),
    .rdata     (m_prdata),
    .ready     (m_pready)
  );
endmodule

// File: rtl/apb_tri_decoder_chk.sv
module apb_tri_decoder_chk
  import apb_tri_dec_pkg::*;
(
  input logic                     m_psel,
  input logic                     m_penable,
  input logic                     m_pwrite,
  input logic [ADDR_W-1:0]        m_paddr,
  input logic [DATA_W-1:0]        m_pwdata,
  input logic [DATA_W-1:0]        m_prdata,
  input logic                     m_pready,
  input logic [SLOT_N-1:0]        s_psel,
  input logic                     s_penable,
  input logic                     s_pwrite,
  input logic [OFS_W-1:0]         s_paddr,
  input logic [DATA_W-1:0]        s_pwdata,
  input logic [SLOT_N*DATA_W-1:0] s_prdata,
  input logic [SLOT_N-1:0]        s_pready
);
  logic unmapped;
  assign unmapped = (m_paddr[ADDR_W-1:OFS_W] < FIRST_PAGE) ||
                    (m_paddr[ADDR_W-1:OFS_W] >= FIRST_PAGE + PAGE_W'(SLOT_N));

  always_comb begin
    AST_ONE_SEL: assert ($countones(s_psel) <= 1) else $error("multiple selects"); // R4
    AST_IDLE_NO_SEL: assert (m_psel || s_psel == '0) else $error("select without requester select"); // R4
    AST_UNMAPPED_RSP: assert (!unmapped || (s_psel == '0 && m_prdata == '0 && m_pready)) else $error("unmapped response"); // R8
    AST_BCAST: assert (s_penable == m_penable && s_pwrite == m_pwrite && s_pwdata == m_pwdata) else $error("broadcast mismatch"); // R5
    AST_OFFSET: assert (s_paddr == m_paddr[OFS_W-1:0]) else $error("offset mismatch"); // R6
  end
endmodule

bind apb_tri_decoder apb_tri_decoder_chk chk_i (.*);

// File: tb/apb_tri_decoder_tb_top.sv
`timescale 1ns/1ps
module apb_tri_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        m_psel = 0, m_penable = 0, m_pwrite = 0;
  logic [31:0] m_paddr = '0, m_pwdata = '0;
  logic [31:0] m_prdata;
  logic        m_pready;
  logic [2:0]  s_psel;
  logic        s_penable, s_pwrite;
  logic [7:0]  s_paddr;
  logic [31:0] s_pwdata;
  logic [95:0] s_prdata = {32'hC3C3_0002, 32'hB2B2_0001, 32'hA1A1_0000};
  logic [2:0]  s_pready = 3'b000;

  apb_tri_decoder dut_i (.*);

  typedef struct {
    string       tag;
    logic [2:0]  sel;
    logic [31:0] rdata;
    logic        rdy;
    logic [7:0]  ofs;
    logic        en, wr;
    logic [31:0] wd;
  } exp_t;

  exp_t exp_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one transfer per cycle and push the model's prediction
  task automatic drive(string tag, logic sel, logic en, logic wr, logic [31:0] a, logic [31:0] wd, logic [2:0] rdy);
    exp_t e;
    int idx;
    @(posedge clk);
    #1;
    m_psel = sel; m_penable = en; m_pwrite = wr; m_paddr = a; m_pwdata = wd; s_pready = rdy;
    idx = -1;
    if (a[31:8] == 24'h400500) idx = 0;
    else if (a[31:8] == 24'h400501) idx = 1;
    else if (a[31:8] == 24'h400502) idx = 2;
    e.tag = tag;
    e.sel = (idx >= 0 && sel) ? 3'(1 << idx) : 3'b000;
    e.rdata = (idx >= 0) ? s_prdata[idx*32 +: 32] : 32'h0;
    e.rdy = (idx >= 0) ? rdy[idx] : 1'b1;
    e.ofs = a[7:0];
    e.en = en; e.wr = wr; e.wd = wd;
    exp_q.push_back(e);
  endtask

  // monitor: compare at the falling edge, away from the driving edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "sel", {29'h0, s_psel}, {29'h0, e.sel});
      chk(e.tag, "rdata", m_prdata, e.rdata);
      chk(e.tag, "ready", {31'h0, m_pready}, {31'h0, e.rdy});
      chk({e.tag, "/R6"}, "offset", {24'h0, s_paddr}, {24'h0, e.ofs});
      chk({e.tag, "/R5"}, "bcast", {s_pwdata[29:0], s_penable, s_pwrite}, {e.wd[29:0], e.en, e.wr});
      chk({e.tag, "/R5"}, "wdata", s_pwdata, e.wd);
    end
  end

  initial begin
    #20;
    // reset state: idle requester, no select
    chk("R4", "reset sel", {29'h0, s_psel}, 32'h0);
    rst_n = 1'b1;
    drive("R1", 1, 0, 0, 32'h4005_0004, 32'h0, 3'b001);
    drive("R1", 1, 1, 0, 32'h4005_0004, 32'h0, 3'b001);
    drive("R7", 1, 1, 0, 32'h4005_0010, 32'h0, 3'b110);
    drive("R2", 1, 0, 1, 32'h4005_010F, 32'h1234_5678, 3'b010);
    drive("R2", 1, 1, 1, 32'h4005_010F, 32'h1234_5678, 3'b010);
    drive("R7", 1, 1, 0, 32'h4005_0180, 32'h0, 3'b101);
    drive("R3", 1, 1, 1, 32'h4005_0233, 32'hDEAD_BEEF, 3'b100);
    drive("R7", 1, 1, 0, 32'h4005_02F0, 32'h0, 3'b011);
    drive("R4", 0, 0, 1, 32'h4005_0004, 32'h5555_AAAA, 3'b111);
    drive("R4", 0, 1, 0, 32'h4005_0110, 32'h0, 3'b111);
    drive("R4", 0, 0, 0, 32'h4005_0220, 32'h0, 3'b000);
    drive("R8", 1, 1, 0, 32'h4005_0300, 32'h0, 3'b000);
    drive("R8", 1, 1, 1, 32'h0000_0000, 32'hFFFF_FFFF, 3'b000);
    drive("R8", 1, 0, 0, 32'h4004_FFFF, 32'h0, 3'b000);
    drive("R9", 1, 1, 0, 32'h4005_00FF, 32'h0, 3'b111);
    drive("R9", 1, 1, 0, 32'h4005_0100, 32'h0, 3'b111);
    drive("R9", 1, 1, 0, 32'h4005_01FF, 32'h0, 3'b110);
    drive("R9", 1, 1, 0, 32'h4005_0200, 32'h0, 3'b100);
    drive("R9", 1, 1, 0, 32'h4005_02FF, 32'h0, 3'b011);
    drive("R9", 1, 1, 0, 32'h4005_FFFF, 32'h0, 3'b000);
    repeat (3) @(posedge clk);
    done = 1;
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (done || wd_cnt == 5000) begin
      if (!done) begin
        n_fail++;
        $display("FAIL watchdog act=timeout exp=completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule